// File: doc/BRIEF.md
# Flash command sequence decoder

This block watches the write cycles that a host places on a parallel flash bus and recognises the multi-cycle command sequences that the device understands. Each write offers an address, a data byte and a one-cycle write strobe. The decoder follows the two-write unlock prefix. It decodes the normal program and the two six-write erase sequences (whole chip and single sector). It also handles a bypass mode in which a program takes only two writes. For each completed command it raises a one-cycle pulse towards the embedded algorithm engine, together with the captured address and data.

The engine drives a busy input while an algorithm runs, and the decoder ignores every write during that time. A bus-side hardware reset, or the synchronous system reset, drops any partly entered sequence and any bypass session. The decoder reports two mode flags. One shows that it is idle in array-read mode. The other shows that it is in bypass mode. All outputs are registered and change on the clock edge that samples the write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst` or `bus_reset` is high at an edge, the decoder returns to array-read mode (`in_array_read`=1, `in_bypass`=0) and raises no pulse on the next cycle, even if a write is presented in the same cycle.
- R2: The unlock prefix is data AAh at address 555h followed by data 55h at address 2AAh. Only the low 11 address bits are compared, and upper address bits are ignored.
- R3: A normal program is unlock prefix, A0h, then one write whose address and data appear on `prog_addr`/`prog_data` with `prog_pulse` high for exactly one cycle, in the cycle after that write.
- R4: Chip erase is unlock prefix, 80h, unlock prefix, 10h, and it raises `chip_erase_pulse` for one cycle after the last write.
- R5: Sector erase is unlock prefix, 80h, unlock prefix, 30h. It raises `sect_erase_pulse` for one cycle, with `sect_addr` equal to the address of the 30h write.
- R6: Unlock prefix followed by 20h enters bypass mode: `in_bypass`=1, `in_array_read`=0.
- R7: In bypass mode, A0h followed by one address/data write raises `prog_pulse` with that address and data, and the block stays in bypass mode. This repeats for any number of programs.
- R8: In bypass mode, 90h followed by 00h (any addresses) leaves bypass mode and returns to array-read mode.
- R9: In bypass mode every other write is ignored and bypass mode is kept. A second write after 90h that is not 00h keeps bypass mode.
- R10: Outside bypass mode, a write that does not match the expected next cycle of a sequence returns the decoder to array-read mode with no pulse.
- R11: A write presented while `busy` is high is ignored: no pulse and no change of mode or sequence progress.
- R12: `in_array_read` is high exactly when no sequence is partly entered and bypass mode is off. `in_array_read` and `in_bypass` are never both high, and at most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_reset | input | 1 | Synchronous active-high hardware reset from the flash bus |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the command byte is bits 7:0 |
| busy | input | 1 | Embedded algorithm running; writes are ignored |
| prog_pulse | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| chip_erase_pulse | output | 1 | One-cycle chip erase request |
| sect_erase_pulse | output | 1 | One-cycle sector erase request |
| sect_addr | output | ADDR_W | Address of the sector to erase |
| in_array_read | output | 1 | Idle in array-read mode |
| in_bypass | output | 1 | Bypass mode active |

## Verification
Two functions of this decoder can meet in one cycle. The final write of a command can coincide with the bus reset, or with busy from the engine. The bench places the bus reset exactly on the 10h write of a chip erase and on a bypass program data write. It places busy on the 30h write of a sector erase and on the middle of an unlock prefix. Reset must win with no pulse and array-read mode. Busy must leave the sequence where it was, so that repeating the write without busy still completes the command. The random phase raises both inputs at random against sequences that are mostly well formed, and a bench model judges every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  // Sequence position of the decoder
  typedef enum logic [3:0] {
    ST_READ,    // idle, array read
    ST_UNL1,    // first unlock seen
    ST_UNL2,    // full unlock seen
    ST_PGM,     // waiting program address/data
    ST_SETUP,   // erase setup seen
    ST_ERA1,    // first unlock after setup
    ST_ERA2,    // second unlock after setup
    ST_BYP,     // bypass idle
    ST_BPGM,    // bypass program, waiting address/data
    ST_BEXIT    // bypass exit, waiting 00h
  } seq_state_t;

  // Indices into the command hit vector
  localparam int K_UNL1  = 0;
  localparam int K_UNL2  = 1;
  localparam int K_PGM   = 2;
  localparam int K_SETUP = 3;
  localparam int K_BYP   = 4;
  localparam int K_CHIP  = 5;
  localparam int K_SECT  = 6;
  localparam int K_BEXIT = 7;
  localparam int K_ZERO  = 8;
  localparam int NUM_CODES = 9;

  localparam int CMD_W = 8;

  function automatic logic [CMD_W-1:0] cmd_code(input int idx);
    case (idx)
      K_UNL1:  return 8'hAA;
      K_UNL2:  return 8'h55;
      K_PGM:   return 8'hA0;
      K_SETUP: return 8'h80;
      K_BYP:   return 8'h20;
      K_CHIP:  return 8'h10;
      K_SECT:  return 8'h30;
      K_BEXIT: return 8'h90;
      K_ZERO:  return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_bypass(input seq_state_t s);
    return (s == ST_BYP) || (s == ST_BPGM) || (s == ST_BEXIT);
  endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int UNLOCK_AW = 11,
  parameter logic [UNLOCK_AW-1:0] UNL_ADDR1 = 'h555,
  parameter logic [UNLOCK_AW-1:0] UNL_ADDR2 = 'h2AA
) (
  input  logic [CMD_W-1:0]     cmd_byte,
  input  logic [UNLOCK_AW-1:0] unl_addr,
  output logic [NUM_CODES-1:0] hit
);

  logic [NUM_CODES-1:0] data_hit;
  logic                 addr1_ok;
  logic                 addr2_ok;

  // One comparator per known command code
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    assign data_hit[g] = (cmd_byte == cmd_code(g));
  end

  assign addr1_ok = (unl_addr == UNL_ADDR1);
  assign addr2_ok = (unl_addr == UNL_ADDR2);

  always_comb begin
    hit         = data_hit;
    hit[K_UNL1] = data_hit[K_UNL1] & addr1_ok;
    hit[K_UNL2] = data_hit[K_UNL2] & addr2_ok;
  end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic                 busy,
  input  logic [NUM_CODES-1:0] hit,
  output seq_state_t           state_d,
  output logic                 do_prog,
  output logic                 do_chip,
  output logic                 do_sect
);

  seq_state_t state_q;
  logic       accept;

  assign accept = wr_en & ~busy;

  always_comb begin
    state_d = state_q;
    do_prog = 1'b0;
    do_chip = 1'b0;
    do_sect = 1'b0;
    if (clr) begin
      state_d = ST_READ;
    end else if (accept) begin
      unique case (state_q)
        ST_READ:  state_d = hit[K_UNL1] ? ST_UNL1 : ST_READ;
        ST_UNL1:  state_d = hit[K_UNL2] ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (hit[K_PGM])        state_d = ST_PGM;
          else if (hit[K_SETUP]) state_d = ST_SETUP;
          else if (hit[K_BYP])   state_d = ST_BYP;
          else                   state_d = ST_READ;
        end
        ST_PGM: begin
          do_prog = 1'b1;
          state_d = ST_READ;
        end
        ST_SETUP: state_d = hit[K_UNL1] ? ST_ERA1 : ST_READ;
        ST_ERA1:  state_d = hit[K_UNL2] ? ST_ERA2 : ST_READ;
        ST_ERA2: begin
          do_chip = hit[K_CHIP];
          do_sect = hit[K_SECT];
          state_d = ST_READ;
        end
        ST_BYP: begin
          if (hit[K_PGM])        state_d = ST_BPGM;
          else if (hit[K_BEXIT]) state_d = ST_BEXIT;
          else                   state_d = ST_BYP;
        end
        ST_BPGM: begin
          do_prog = 1'b1;
          state_d = ST_BYP;
        end
        ST_BEXIT: state_d = hit[K_ZERO] ? ST_READ : ST_BYP;
        default:  state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

endmodule

// File: rtl/flash_act_reg.sv
module flash_act_reg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  seq_state_t        state_d,
  input  logic              do_prog,
  input  logic              do_chip,
  input  logic              do_sect,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_pulse,
  output logic              sect_erase_pulse,
  output logic [ADDR_W-1:0] sect_addr,
  output logic              in_array_read,
  output logic              in_bypass
);

  always_ff @(posedge clk) begin
    if (clr) begin
      prog_pulse       <= 1'b0;
      chip_erase_pulse <= 1'b0;
      sect_erase_pulse <= 1'b0;
      in_array_read    <= 1'b1;
      in_bypass        <= 1'b0;
    end else begin
      prog_pulse       <= do_prog;
      chip_erase_pulse <= do_chip;
      sect_erase_pulse <= do_sect;
      in_array_read    <= (state_d == ST_READ);
      in_bypass        <= is_bypass(state_d);
    end
  end

  // Payload registers load only with their pulse
  always_ff @(posedge clk) begin
    if (clr) begin
      prog_addr <= '0;
      prog_data <= '0;
      sect_addr <= '0;
    end else begin
      if (do_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (do_sect) begin
        sect_addr <= wr_addr;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int UNLOCK_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_pulse,
  output logic              sect_erase_pulse,
  output logic [ADDR_W-1:0] sect_addr,
  output logic              in_array_read,
  output logic              in_bypass
);

  logic [NUM_CODES-1:0] hit;
  seq_state_t           state_d;
  logic                 do_prog;
  logic                 do_chip;
  logic                 do_sect;
  logic                 clr;

  assign clr = rst | bus_reset;

  flash_cmd_match #(
    .UNLOCK_AW (UNLOCK_AW)
  ) i_match (
    .cmd_byte (wr_data[CMD_W-1:0]),
    .unl_addr (wr_addr[UNLOCK_AW-1:0]),
    .hit      (hit)
  );

  flash_seq_fsm i_fsm (
    .clk     (clk),
    .clr     (clr),
    .wr_en   (wr_en),
    .busy    (busy),
    .hit     (hit),
    .state_d (state_d),
    .do_prog (do_prog),
    .do_chip (do_chip),
    .do_sect (do_sect)
  );

  flash_act_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_act (
    .clk              (clk),
    .clr              (clr),
    .state_d          (state_d),
    .do_prog          (do_prog),
    .do_chip          (do_chip),
    .do_sect          (do_sect),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .prog_pulse       (prog_pulse),
    .prog_addr        (prog_addr),
    .prog_data        (prog_data),
    .chip_erase_pulse (chip_erase_pulse),
    .sect_erase_pulse (sect_erase_pulse),
    .sect_addr        (sect_addr),
    .in_array_read    (in_array_read),
    .in_bypass        (in_bypass)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int UNLOCK_AW = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_reset,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              prog_pulse,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              chip_erase_pulse,
  input logic              sect_erase_pulse,
  input logic [ADDR_W-1:0] sect_addr,
  input logic              in_array_read,
  input logic              in_bypass
);

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_pulse, chip_erase_pulse, sect_erase_pulse}));

  assert_mode_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(in_array_read && in_bypass));

  assert_bus_reset_R1: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (in_array_read && !in_bypass &&
                   !(prog_pulse || chip_erase_pulse || sect_erase_pulse)));

  assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_reset) |=> (!(prog_pulse || chip_erase_pulse || sect_erase_pulse) &&
                              $stable(in_bypass) && $stable(in_array_read)));

  assert_chip_src_R4: assert property (@(posedge clk) disable iff (rst)
    chip_erase_pulse |-> $past(wr_en && !busy && wr_data[7:0] == 8'h10));

  assert_sect_addr_R5: assert property (@(posedge clk) disable iff (rst)
    sect_erase_pulse |-> (sect_addr == $past(wr_addr) && $past(wr_data[7:0]) == 8'h30));

  assert_prog_payload_R3: assert property (@(posedge clk) disable iff (rst)
    prog_pulse |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

  assert_bypass_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(in_bypass) |-> $past(wr_en && !busy && wr_data[7:0] == 8'h20));

  assert_bypass_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (in_bypass && !bus_reset && !(wr_en && !busy && wr_data[7:0] == 8'h00)) |=> in_bypass);

  assert_bypass_exit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(in_bypass) |-> ($past(rst) || $past(bus_reset) ||
                          $past(wr_en && !busy && wr_data[7:0] == 8'h00)));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .UNLOCK_AW (UNLOCK_AW)
) i_chk (.*);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int AW = 19;
  localparam int DW = 8;

  // model positions
  localparam int M_READ = 0, M_UNL1 = 1, M_UNL2 = 2, M_PGM = 3, M_SETUP = 4;
  localparam int M_ERA1 = 5, M_ERA2 = 6, M_BYP = 7, M_BPGM = 8, M_BEXIT = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_reset = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          prog_pulse, chip_erase_pulse, sect_erase_pulse;
  logic [AW-1:0] prog_addr, sect_addr;
  logic [DW-1:0] prog_data;
  logic          in_array_read, in_bypass;

  always #4 clk = ~clk;   // 125 MHz

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .prog_pulse(prog_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_pulse(chip_erase_pulse), .sect_erase_pulse(sect_erase_pulse),
    .sect_addr(sect_addr), .in_array_read(in_array_read), .in_bypass(in_bypass)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int            m_st = M_READ;
  logic          e_prog = 0, e_chip = 0, e_sect = 0;
  logic [AW-1:0] e_paddr = '0, e_saddr = '0;
  logic [DW-1:0] e_pdata = '0;
  string         prev_tag = "R1";

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference behaviour derived from the requirements
  task automatic model(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic b, input logic hr);
    logic u1, u2;
    e_prog = 0; e_chip = 0; e_sect = 0;
    u1 = (d == 8'hAA) && (a[10:0] == 11'h555);
    u2 = (d == 8'h55) && (a[10:0] == 11'h2AA);
    if (hr) m_st = M_READ;
    else if (we && !b) begin
      case (m_st)
        M_READ:  m_st = u1 ? M_UNL1 : M_READ;
        M_UNL1:  m_st = u2 ? M_UNL2 : M_READ;
        M_UNL2:  m_st = (d == 8'hA0) ? M_PGM : (d == 8'h80) ? M_SETUP :
                        (d == 8'h20) ? M_BYP : M_READ;
        M_PGM:   begin e_prog = 1; e_paddr = a; e_pdata = d; m_st = M_READ; end
        M_SETUP: m_st = u1 ? M_ERA1 : M_READ;
        M_ERA1:  m_st = u2 ? M_ERA2 : M_READ;
        M_ERA2:  begin
          e_chip = (d == 8'h10);
          e_sect = (d == 8'h30);
          if (e_sect) e_saddr = a;
          m_st = M_READ;
        end
        M_BYP:   m_st = (d == 8'hA0) ? M_BPGM : (d == 8'h90) ? M_BEXIT : M_BYP;
        M_BPGM:  begin e_prog = 1; e_paddr = a; e_pdata = d; m_st = M_BYP; end
        M_BEXIT: m_st = (d == 8'h00) ? M_READ : M_BYP;
        default: m_st = M_READ;
      endcase
    end
  endtask

  task automatic check_outputs();
    chk(prog_pulse == e_prog, {prev_tag, " R3 R7"}, "prog_pulse", 32'(prog_pulse), 32'(e_prog));
    if (e_prog) begin
      chk(prog_addr == e_paddr, {prev_tag, " R3 R7"}, "prog_addr", 32'(prog_addr), 32'(e_paddr));
      chk(prog_data == e_pdata, {prev_tag, " R3 R7"}, "prog_data", 32'(prog_data), 32'(e_pdata));
    end
    chk(chip_erase_pulse == e_chip, {prev_tag, " R4"}, "chip_erase_pulse",
        32'(chip_erase_pulse), 32'(e_chip));
    chk(sect_erase_pulse == e_sect, {prev_tag, " R5"}, "sect_erase_pulse",
        32'(sect_erase_pulse), 32'(e_sect));
    if (e_sect)
      chk(sect_addr == e_saddr, {prev_tag, " R5"}, "sect_addr", 32'(sect_addr), 32'(e_saddr));
    chk(in_bypass == (m_st >= M_BYP), {prev_tag, " R6 R8 R9"}, "in_bypass",
        32'(in_bypass), 32'(m_st >= M_BYP));
    chk(in_array_read == (m_st == M_READ), {prev_tag, " R2 R10 R12"}, "in_array_read",
        32'(in_array_read), 32'(m_st == M_READ));
  endtask

  // One bus cycle: check the result of the previous cycle, then drive this one
  task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic b, input logic hr, input string tag);
    @(negedge clk);
    check_outputs();
    wr_en = we; wr_addr = a; wr_data = d; busy = b; bus_reset = hr;
    model(we, a, d, b, hr);
    prev_tag = tag;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic unlock(input string tag);
    wr(19'h00555, 8'hAA, tag);
    wr(19'h002AA, 8'h55, tag);
  endtask

  // Next well-formed write for the model position, used by the random phase
  function automatic logic [AW+DW-1:0] good_write(input int st, input logic [31:0] r);
    logic [AW-1:0] ra;
    ra = AW'(r >> 4);
    case (st)
      M_READ, M_SETUP: return {ra[AW-1:11], 11'h555, 8'hAA};
      M_UNL1, M_ERA1:  return {ra[AW-1:11], 11'h2AA, 8'h55};
      M_UNL2:          return {ra, (r[1:0] == 0) ? 8'hA0 : (r[1:0] == 1) ? 8'h20 : 8'h80};
      M_ERA2:          return {ra, r[0] ? 8'h30 : 8'h10};
      M_BYP:           return {ra, (r[1:0] == 0) ? 8'h90 : 8'hA0};
      M_BEXIT:         return {ra, 8'h00};
      default:         return {ra, r[31:24]};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_array_read == 1'b1, "R1", "in_array_read after reset", 32'(in_array_read), 1);
    chk(in_bypass == 1'b0, "R1", "in_bypass after reset", 32'(in_bypass), 0);
    chk(!(prog_pulse | chip_erase_pulse | sect_erase_pulse), "R1", "pulses after reset",
        {29'd0, prog_pulse, chip_erase_pulse, sect_erase_pulse}, 0);
    rst = 1'b0;

    // R3 normal program
    unlock("R3"); wr(19'h00000, 8'hA0, "R3"); wr(19'h12345, 8'h5A, "R3");
    // R2 upper address bits ignored on unlock
    wr(19'h7D555, 8'hAA, "R2"); wr(19'h402AA, 8'h55, "R2");
    wr(19'h00001, 8'hA0, "R2"); wr(19'h3FFFF, 8'hC3, "R2");
    // R4 chip erase
    unlock("R4"); wr(19'h00555, 8'h80, "R4"); unlock("R4"); wr(19'h00555, 8'h10, "R4");
    // R5 sector erase
    unlock("R5"); wr(19'h00555, 8'h80, "R5"); unlock("R5"); wr(19'h40000, 8'h30, "R5");
    // R10 wrong unlock address, then stray A0
    wr(19'h00555, 8'hAA, "R10"); wr(19'h002AB, 8'h55, "R10");
    wr(19'h00000, 8'hA0, "R10"); wr(19'h00010, 8'h77, "R10");
    unlock("R10"); wr(19'h00555, 8'h80, "R10"); wr(19'h00555, 8'h10, "R10");
    // R6 bypass entry, R7 two bypass programs
    unlock("R6"); wr(19'h00555, 8'h20, "R6");
    wr(19'h00000, 8'hA0, "R7"); wr(19'h00100, 8'h11, "R7");
    wr(19'h00000, 8'hA0, "R7"); wr(19'h7FFFF, 8'hEE, "R7");
    // R9 others ignored in bypass, bad exit keeps bypass
    unlock("R9"); wr(19'h00555, 8'h80, "R9"); wr(19'h00555, 8'h10, "R9");
    wr(19'h00000, 8'h90, "R9"); wr(19'h00000, 8'h55, "R9");
    // R8 exit
    wr(19'h01234, 8'h90, "R8"); wr(19'h04321, 8'h00, "R8");
    wr(19'h00000, 8'hA0, "R8"); wr(19'h00020, 8'h99, "R8");
    // R11 busy mid prefix and on final sector write
    wr(19'h00555, 8'hAA, "R11"); step(1, 19'h002AA, 8'h55, 1, 0, "R11");
    wr(19'h002AA, 8'h55, "R11"); wr(19'h00555, 8'h80, "R11"); unlock("R11");
    step(1, 19'h20000, 8'h30, 1, 0, "R11"); wr(19'h20000, 8'h30, "R11");
    // R1 bus reset on final chip erase write and on bypass program data
    unlock("R1"); wr(19'h00555, 8'h80, "R1"); unlock("R1");
    step(1, 19'h00555, 8'h10, 0, 1, "R1");
    unlock("R1"); wr(19'h00555, 8'h20, "R1"); wr(19'h00000, 8'hA0, "R1");
    step(1, 19'h00444, 8'h44, 0, 1, "R1");
    step(0, 19'h0, 8'h0, 0, 0, "R1");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      logic [AW+DW-1:0] gw;
      logic we, b, hr;
      r  = $urandom;
      we = ($urandom % 8) != 0;
      b  = ($urandom % 12) == 0;
      hr = ($urandom % 80) == 0;
      if (($urandom % 7) == 0) gw = {AW'($urandom), 8'($urandom)};
      else                     gw = good_write(m_st, r);
      step(we, gw[AW+DW-1:DW], gw[DW-1:0], b, hr, "rand R11 R1");
    end
    step(0, 19'h0, 8'h0, 0, 0, "end");
    @(negedge clk);
    check_outputs();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule